// File: doc/BRIEF.md
# Bulk IN Packetizer with Selectable Flush Policy

This block sits between an application byte stream and the endpoint logic of a high-speed USB device. It collects incoming bytes into a single packet buffer of up to 512 bytes. When a packet boundary is reached, it hands the whole packet to the output side as a length plus a one-cycle commit pulse. The output side reads the bytes back by address and releases the buffer with a take strobe. While a packet is waiting for that release, the block stops accepting input.

Where a packet ends is set by a policy bit. In auto mode, a packet is cut as soon as the input stream has nothing to offer, so bytes never sit in the buffer. This suits simple producers, but it leads to many short packets. In explicit mode, a packet ends only when it reaches full size or when the producer pulses flush. Full-sized packets are good for throughput, and the producer decides where transfers end. A transfer that ends exactly on a full packet is closed with a zero-length packet. Auto mode is active after reset. The mode can be changed with a load strobe.

Top module: `bulkin_packetizer`

## Requirements
- R1: `pkt_len` is 10 bits wide and never exceeds 512; a committed packet carries between 0 and 512 bytes.
- R2: In either mode, in the cycle that the 512th byte of a packet is accepted (`s_valid` high while `s_ready` high), the packet is committed: on the next clock `pkt_commit` pulses for one cycle, `pkt_pending` is 1 and `pkt_len` is 512.
- R3: In explicit mode, a `flush` pulse while no packet is pending commits the buffered bytes on the next clock. This includes a byte accepted in the same cycle as the flush.
- R4: In auto mode, a cycle with `s_valid` low while no packet is pending and the buffer is non-empty commits the buffered bytes on the next clock.
- R5: An end event with an empty buffer produces a zero-length commit (`pkt_len` = 0) when the previous committed packet held 512 bytes and no byte has been accepted since. An end event is a flush, a held flush, or in auto mode a cycle with `s_valid` low.
- R6: An end event with an empty buffer produces no commit when the previous packet was shorter than 512 bytes, or when nothing has been committed since reset.
- R7: Only one packet is buffered at a time. From commit until `pkt_take` is sampled high, `s_ready` is 0 and `pkt_pending`, `pkt_len` and the packet bytes are held. `s_ready` returns to 1 on the clock after the take.
- R8: A flush in the same cycle as the 512th byte yields a 512-byte packet, then a zero-length packet right after that packet is taken.
- R9: After reset the block is in auto mode. A cycle with `cfg_load` high sets the mode from `cfg_auto` (1 = auto, 0 = explicit) from the next clock on.
- R10: A `flush` pulse that arrives while a packet is pending is remembered. It is applied in the first cycle after the take.
- R11: While a packet is pending, `rd_data` shows the byte at index `rd_addr` of that packet. Index 0 is the first byte accepted, and bytes are stored in arrival order.
- R12: In explicit mode, idle input with a non-empty buffer and no flush produces no commit, no matter how long it lasts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load the cut policy from `cfg_auto` |
| cfg_auto | input | 1 | Policy value: 1 = cut on empty input, 0 = cut on full or flush only |
| s_data | input | 8 | Input byte |
| s_valid | input | 1 | Input byte available |
| s_ready | output | 1 | Block accepts a byte this cycle |
| flush | input | 1 | End the current transfer |
| pkt_commit | output | 1 | One-cycle pulse: a packet was committed |
| pkt_pending | output | 1 | A committed packet awaits the take |
| pkt_len | output | 10 | Byte count of the pending packet (0 to 512) |
| pkt_take | input | 1 | Output side releases the pending packet |
| rd_addr | input | 9 | Read index into the pending packet |
| rd_data | output | 8 | Byte at `rd_addr` |

## Verification
The assertions check, on every cycle, the rules that depend only on the current state. These are: the length bound, the cut at the 512th byte, the cut on a flush with a partial buffer, holding the pending packet until the take, the rule that a zero-length commit only follows a full packet, and the absence of commits on idle input in explicit mode or with an empty buffer after a short packet. Some behaviours span several steps, and only the bench scenarios show them. These are: a flush held across a pending packet and then turned into a zero-length packet, a full packet followed by a zero-length packet when flush lands on the last byte, the switch between policies, and the byte order read back through the read port.

// File: rtl/bulkin_pkg.sv
package bulkin_pkg;

    // Cut policy selected by cfg_auto
    typedef enum logic {
        CUT_EXPLICIT = 1'b0,
        CUT_AUTO     = 1'b1
    } cut_mode_e;

endpackage

// File: rtl/bulkin_buffer.sv
module bulkin_buffer #(
    parameter int DEPTH = 512,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/bulkin_cutter.sv
module bulkin_cutter
    import bulkin_pkg::*;
#(
    parameter int MAX_PKT = 512,
    localparam int LW     = $clog2(MAX_PKT + 1),
    localparam int AW     = $clog2(MAX_PKT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic          cfg_auto,
    input  logic          s_valid,
    output logic          s_ready,
    input  logic          flush,
    input  logic          pkt_take,
    output logic          pkt_commit,
    output logic          pkt_pending,
    output logic [LW-1:0] pkt_len,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr
);

    localparam logic [LW-1:0] FULL_LEN = LW'(MAX_PKT);

    typedef struct packed {
        logic [LW-1:0] fill;       // bytes gathered for the open packet
        logic          pend;       // committed packet awaiting take
        logic [LW-1:0] len;        // length of committed packet
        logic          commit;     // one-cycle commit pulse
        logic          was_full;   // last commit was full, nothing since
        logic          held_end;   // flush seen while pending
        cut_mode_e     mode;
    } cut_state_t;

    cut_state_t st_q, st_d;

    logic          accept;
    logic [LW-1:0] fill_inc;
    logic          end_evt;

    always_comb begin
        st_d        = st_q;
        st_d.commit = 1'b0;
        accept      = s_valid && !st_q.pend;
        fill_inc    = st_q.fill + LW'(accept);
        end_evt     = flush || st_q.held_end ||
                      ((st_q.mode == CUT_AUTO) && !s_valid);

        if (!st_q.pend) begin
            if (fill_inc == FULL_LEN) begin
                st_d.pend     = 1'b1;
                st_d.len      = FULL_LEN;
                st_d.commit   = 1'b1;
                st_d.was_full = 1'b1;
                st_d.fill     = '0;
                st_d.held_end = flush;
            end else if (end_evt && (fill_inc != '0)) begin
                st_d.pend     = 1'b1;
                st_d.len      = fill_inc;
                st_d.commit   = 1'b1;
                st_d.was_full = 1'b0;
                st_d.fill     = '0;
                st_d.held_end = 1'b0;
            end else if (end_evt && st_q.was_full) begin
                st_d.pend     = 1'b1;
                st_d.len      = '0;
                st_d.commit   = 1'b1;
                st_d.was_full = 1'b0;
                st_d.held_end = 1'b0;
            end else begin
                st_d.fill = fill_inc;
                if (accept) begin
                    st_d.was_full = 1'b0;
                end
                if (end_evt) begin
                    st_d.held_end = 1'b0;
                end
            end
        end else begin
            if (flush) begin
                st_d.held_end = 1'b1;
            end
            if (pkt_take) begin
                st_d.pend = 1'b0;
            end
        end

        if (cfg_load) begin
            st_d.mode = cut_mode_e'(cfg_auto);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.mode     <= CUT_AUTO;
        end else begin
            st_q <= st_d;
        end
    end

    assign s_ready     = !st_q.pend;
    assign pkt_commit  = st_q.commit;
    assign pkt_pending = st_q.pend;
    assign pkt_len     = st_q.len;
    assign wr_en       = accept;
    assign wr_addr     = st_q.fill[AW-1:0];

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.len <= FULL_LEN); // R1

    AST_FULL_CUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && st_q.fill == FULL_LEN - 1'b1)
        |=> (st_q.pend && st_q.commit && st_q.len == FULL_LEN)); // R2

    AST_FLUSH_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !st_q.pend && fill_inc != '0 && fill_inc != FULL_LEN)
        |=> (st_q.pend && st_q.len == $past(fill_inc))); // R3

    AST_ZLP_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.commit && st_q.len == '0) |-> $past(st_q.was_full)); // R5

    AST_SHORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.pend && st_q.fill == '0 && !st_q.was_full && !s_valid)
        |=> !st_q.commit); // R6

    AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !pkt_take) |=> (st_q.pend && $stable(st_q.len))); // R7

    AST_EXPLICIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == CUT_EXPLICIT && !st_q.pend && !flush &&
         !st_q.held_end && !s_valid) |=> !st_q.commit); // R12

endmodule

// File: rtl/bulkin_packetizer.sv
module bulkin_packetizer #(
    parameter int MAX_PKT = 512,
    parameter int DW      = 8,
    localparam int LW     = $clog2(MAX_PKT + 1),
    localparam int AW     = $clog2(MAX_PKT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic          cfg_auto,
    input  logic [DW-1:0] s_data,
    input  logic          s_valid,
    output logic          s_ready,
    input  logic          flush,
    output logic          pkt_commit,
    output logic          pkt_pending,
    output logic [LW-1:0] pkt_len,
    input  logic          pkt_take,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic          wr_en;
    logic [AW-1:0] wr_addr;

    bulkin_cutter #(
        .MAX_PKT (MAX_PKT)
    ) u_cutter (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_load    (cfg_load),
        .cfg_auto    (cfg_auto),
        .s_valid     (s_valid),
        .s_ready     (s_ready),
        .flush       (flush),
        .pkt_take    (pkt_take),
        .pkt_commit  (pkt_commit),
        .pkt_pending (pkt_pending),
        .pkt_len     (pkt_len),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr)
    );

    bulkin_buffer #(
        .DEPTH (MAX_PKT),
        .DW    (DW)
    ) u_buffer (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (s_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: tb/bulkin_packetizer_bench.sv
`timescale 1ns/1ps
module bulkin_packetizer_bench;

    localparam int MAXP = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic       cfg_auto = 1'b0;
    logic [7:0] s_data = '0;
    logic       s_valid = 1'b0;
    logic       s_ready;
    logic       flush = 1'b0;
    logic       pkt_commit;
    logic       pkt_pending;
    logic [9:0] pkt_len;
    logic       pkt_take = 1'b0;
    logic [8:0] rd_addr = '0;
    logic [7:0] rd_data;

    always #2 clk = ~clk;   // 250 MHz

    bulkin_packetizer u_bulkin_packetizer (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_auto(cfg_auto),
        .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready), .flush(flush),
        .pkt_commit(pkt_commit), .pkt_pending(pkt_pending), .pkt_len(pkt_len),
        .pkt_take(pkt_take), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;
    string cur_req = "R9";
    logic [7:0] seq = 8'h11;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [7:0] m_fill[$];
    logic [7:0] m_pkt[$];
    bit m_pend, m_commit, m_lastfull, m_held, m_auto;
    int m_len;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_fill.delete(); m_pkt.delete();
            m_pend = 0; m_commit = 0; m_lastfull = 0; m_held = 0; m_auto = 1; m_len = 0;
        end else begin
            bit take_in, endv;
            take_in = s_valid && !m_pend;
            if (take_in) m_fill.push_back(s_data);
            endv = flush || m_held || (m_auto && !s_valid);
            m_commit = 0;
            if (m_pend) begin
                if (flush) m_held = 1;
                if (pkt_take) m_pend = 0;
            end else if (m_fill.size() == MAXP) begin
                m_pkt = m_fill; m_fill.delete();
                m_pend = 1; m_commit = 1; m_len = MAXP; m_lastfull = 1; m_held = flush;
            end else if (endv && (m_fill.size() > 0 || m_lastfull)) begin
                m_pkt = m_fill; m_fill.delete();
                m_len = m_pkt.size();
                m_pend = 1; m_commit = 1; m_lastfull = 0; m_held = 0;
            end else begin
                if (take_in) m_lastfull = 0;
                if (endv) m_held = 0;
            end
            if (cfg_load) m_auto = cfg_auto;
        end
    end

    // Every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit ok;
            ok = (s_ready == !m_pend) && (pkt_pending == m_pend) &&
                 (pkt_commit == m_commit) && (!m_pend || pkt_len == 10'(m_len));
            chk(ok, cur_req, {pkt_pending, pkt_commit, s_ready}, {m_pend, m_commit, !m_pend});
        end
    end

    task automatic finish_up();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            chk(1'b0, "watchdog", wd, 150000);
            finish_up();
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int n, input bit fl_last);
        int i = 0;
        while (i < n) begin
            @(negedge clk);
            s_valid = 1'b1;
            s_data  = seq;
            flush   = fl_last && (i == n - 1) && s_ready;
            if (s_ready) begin
                i++;
                seq = seq + 8'd7;
            end
        end
        @(negedge clk);
        s_valid = 1'b0;
        flush   = 1'b0;
    endtask

    task automatic pulse_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    task automatic set_mode(input bit a);
        @(negedge clk); cfg_load = 1'b1; cfg_auto = a;
        @(negedge clk); cfg_load = 1'b0;
    endtask

    task automatic wait_pend(input int exp_len, input string req);
        int n = 0;
        while (!pkt_pending && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(pkt_pending === 1'b1, req, pkt_pending, 1);
        chk(pkt_len == 10'(exp_len), req, pkt_len, exp_len);
    endtask

    task automatic take_pkt(input string req);
        int bad = 0;
        int first_act = 0, first_exp = 0;
        for (int a = 0; a < int'(pkt_len); a++) begin
            @(negedge clk);
            rd_addr = 9'(a);
            #1;
            if (rd_data !== m_pkt[a]) begin
                if (bad == 0) begin first_act = rd_data; first_exp = m_pkt[a]; end
                bad++;
            end
        end
        chk(bad == 0, req, first_act, first_exp);
        chk(s_ready == 1'b0, "R7", s_ready, 0);
        @(negedge clk); pkt_take = 1'b1;
        @(negedge clk); pkt_take = 1'b0;
        chk(s_ready == 1'b1 && pkt_pending == 1'b0, "R7", s_ready, 1);
    endtask

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        cur_req = "R9";
        chk(s_ready == 1'b1, "R9", s_ready, 1);
        chk(pkt_pending == 1'b0 && pkt_commit == 1'b0, "R9", pkt_pending, 0);

        // Auto policy by default: short burst cut when input goes idle
        cur_req = "R4";
        send(3, 1'b0);
        wait_pend(3, "R4");
        take_pkt("R11");
        idle(3);
        chk(pkt_pending == 1'b0, "R6", pkt_pending, 0);

        // Explicit policy: idle does not cut, flush does
        set_mode(1'b0);
        cur_req = "R12";
        send(5, 1'b0);
        idle(8);
        chk(pkt_pending == 1'b0, "R12", pkt_pending, 0);
        cur_req = "R3";
        pulse_flush();
        wait_pend(5, "R3");
        take_pkt("R11");

        // Flush carried on the last byte of a partial packet
        send(200, 1'b1);
        wait_pend(200, "R3");
        take_pkt("R11");

        // Flush with empty buffer after a short packet: nothing
        cur_req = "R6";
        pulse_flush();
        idle(4);
        chk(pkt_pending == 1'b0 && pkt_commit == 1'b0, "R6", pkt_pending, 0);

        // Full packet, flush while pending is held, ZLP after take
        cur_req = "R2";
        send(MAXP, 1'b0);
        wait_pend(MAXP, "R2");
        cur_req = "R7";
        idle(3);
        chk(s_ready == 1'b0 && pkt_len == 10'd512, "R7", pkt_len, 512);
        cur_req = "R10";
        pulse_flush();
        take_pkt("R11");
        wait_pend(0, "R10");
        take_pkt("R5");
        idle(3);
        chk(pkt_pending == 1'b0, "R5", pkt_pending, 0);

        // Flush on the 512th byte: full packet then ZLP
        cur_req = "R8";
        send(MAXP, 1'b1);
        wait_pend(MAXP, "R8");
        take_pkt("R8");
        wait_pend(0, "R8");
        take_pkt("R8");
        idle(4);
        chk(pkt_pending == 1'b0, "R8", pkt_pending, 0);

        // Back to auto: full packet then idle yields ZLP
        set_mode(1'b1);
        cur_req = "R5";
        send(MAXP, 1'b0);
        wait_pend(MAXP, "R1");
        take_pkt("R11");
        wait_pend(0, "R5");
        take_pkt("R5");
        idle(4);
        chk(pkt_pending == 1'b0, "R6", pkt_pending, 0);

        finish_up();
    end

endmodule